// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a 16-bit up-counter with a programmable wrap point. A clock divider feeds it. Software chooses the counting rate: the bus clock divided by a power of two from 1 to 64, or the rising edges of an external clock pin. The counter climbs to the programmed modulo value, raises an overflow flag and returns to zero on the next count. A pending overflow can drive an interrupt line.

All control goes through a small byte-wide register bus. One control byte holds the overflow flag, the interrupt enable, a run/halt bit, a write-only restart bit and the rate select. Four more byte addresses expose the counter (read-only) and the modulo value. A flag can be cleared only by reading it as set and then writing zero to it. An overflow that arrives between the read and the write cancels the clear, so no overflow event is lost. The timer comes out of reset halted and free-running (modulo 0xFFFF), and waits for software to start it.

Register addresses: 0 control, 1 counter high byte, 2 counter low byte, 3 modulo high byte, 4 modulo low byte. Control byte fields: bit 0 overflow flag, bit 1 interrupt enable, bit 2 halt, bit 3 restart (write-only, reads 0), bits 6:4 rate select, bit 7 reads 0.

Top module: `presc_mod_timer`

## Requirements
- R1: After reset the control byte reads 0x04 (halted, flag and enable clear, select 000), the counter reads 0x0000, the modulo reads 0xFFFF and `irq` is low.
- R2: Select codes 000 to 110 advance the counter once every 2^code bus clocks: counting from a restart, the counter holds floor(N / 2^code) after N clocks.
- R3: Select code 111 advances the counter once for each rising edge of `ext_clk`, taken through a two-flop synchronizer, and not at all while `ext_clk` holds steady.
- R4: The counter goes back to 0x0000 on the count after it equals the modulo value. A write to the modulo high byte is staged and becomes visible only when the low byte is written.
- R5: The overflow flag (control bit 0) goes to 1 in the same clock in which the counter takes the modulo value.
- R6: A write of 0 to the flag clears it only if the control byte was read while the flag was 1, with no other control write in between. Without that read the write of 0 leaves the flag unchanged.
- R7: If an overflow occurs after the arming read and before the write of 0, that write does not clear the flag.
- R8: Writing 1 to the flag bit neither sets nor clears the flag.
- R9: `irq` is high exactly while both the flag and the interrupt enable (control bit 1) are 1.
- R10: While the halt bit (control bit 2) is 1 the counter keeps its value. Clearing the bit resumes counting from that value.
- R11: Writing 1 to the restart bit (control bit 3) zeroes the counter and the divider in that clock. The interrupt enable, halt, select and modulo take the values written or keep their values, and the restart bit always reads 0.
- R12: A single write that sets both the halt and the restart bits leaves the counter at 0x0000 and holding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_clk | input | 1 | External count source, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
A register write takes effect at the clock edge on which its strobe is sampled. Read data is combinational, so the bench drives strobes on the falling edge and samples read data 1 ns later, before the next rising edge. The counter value is due one edge after each divider tick. From a restart at edge 0, the tick for code k falls on edges that are multiples of 2^k, and the bench reads the counter after a known number of edges. For the overflow race, the bench places the arming read, the overflow edge and the write of 0 on edges counted from a halted restart. The external edge test allows the two synchronizer flops, the edge detect and the counter register before it samples.

// File: rtl/presc_mod_timer_pkg.sv
package presc_mod_timer_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 2 * DATA_W;

    // control byte field positions
    localparam int B_FLAG  = 0;
    localparam int B_IEN   = 1;
    localparam int B_HALT  = 2;
    localparam int B_RSTRT = 3;
    localparam int B_SEL   = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_CNT_LO = 3'd2,
        RA_MOD_HI = 3'd3,
        RA_MOD_LO = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic             flag;
        logic             ien;
        logic             halt;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic             wrap;
        logic             hit;
        logic [CNT_W-1:0] nxt;
    } step_t;

    // next counter state for one tick
    function automatic step_t count_step(input logic [CNT_W-1:0] cur,
                                         input logic [CNT_W-1:0] lim);
        step_t s;
        logic [CNT_W-1:0] inc;
        inc    = cur + CNT_W'(1);
        s.wrap = (cur >= lim);
        s.hit  = !s.wrap && (inc == lim);
        s.nxt  = s.wrap ? '0 : inc;
        return s;
    endfunction

endpackage

// File: rtl/presc_mod_timer_div.sv
module presc_mod_timer_div #(
    parameter int SEL_W = presc_mod_timer_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_in,
    output logic             tick
);
    localparam int NCODE  = 1 << SEL_W;
    localparam int STAGES = NCODE - 2;

    logic [STAGES-1:0] div_q;
    logic [2:0]        sync_q;
    logic [NCODE-1:0]  tap;
    logic              ext_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_in};
            if (restart)
                div_q <= '0;
            else if (!halt)
                div_q <= div_q + STAGES'(1);
        end
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    // code 0 ticks every clock, code c when the low c bits are all ones
    assign tap[0] = 1'b1;
    for (genvar g = 1; g <= STAGES; g++) begin : g_tap
        assign tap[g] = &div_q[g-1:0];
    end
    assign tap[NCODE-1] = ext_rise;

    assign tick = !halt && tap[sel];

endmodule

// File: rtl/presc_mod_timer_cnt.sv
module presc_mod_timer_cnt #(
    parameter int CNT_W = presc_mod_timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    import presc_mod_timer_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    step_t            st;

    assign st = count_step(cnt_q, modulo);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= st.nxt;
    end

    assign ovf_evt = tick && !restart && st.hit;
    assign count   = cnt_q;

endmodule

// File: rtl/presc_mod_timer_regs.sv
module presc_mod_timer_regs #(
    parameter int DATA_W = presc_mod_timer_pkg::DATA_W,
    parameter int ADDR_W = presc_mod_timer_pkg::ADDR_W,
    parameter int SEL_W  = presc_mod_timer_pkg::SEL_W,
    parameter int CNT_W  = presc_mod_timer_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf_evt,
    output logic              halt,
    output logic [SEL_W-1:0]  sel,
    output logic              restart,
    output logic [CNT_W-1:0]  modulo,
    output logic              flag,
    output logic              ien,
    output logic              irq
);
    import presc_mod_timer_pkg::*;

    ctrl_t             ctrl_q;
    logic              arm_q;
    logic [CNT_W-1:0]  mod_q;
    logic [DATA_W-1:0] mod_hi_stage_q;
    logic              ctrl_wr, ctrl_rd, clear_ok;
    logic              unused_wbit;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
    assign ctrl_rd  = bus_rd && (bus_addr == ADDR_W'(RA_CTRL));
    assign clear_ok = ctrl_wr && arm_q && !bus_wdata[B_FLAG];
    assign restart  = ctrl_wr && bus_wdata[B_RSTRT];
    assign unused_wbit = bus_wdata[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.flag <= 1'b0;
            ctrl_q.ien  <= 1'b0;
            ctrl_q.halt <= 1'b1;
            ctrl_q.sel  <= '0;
        end else begin
            if (ovf_evt)
                ctrl_q.flag <= 1'b1;
            else if (clear_ok)
                ctrl_q.flag <= 1'b0;
            if (ctrl_wr) begin
                ctrl_q.ien  <= bus_wdata[B_IEN];
                ctrl_q.halt <= bus_wdata[B_HALT];
                ctrl_q.sel  <= bus_wdata[B_SEL +: SEL_W];
            end
        end
    end

    // arming of the flag clear sequence
    always_ff @(posedge clk) begin
        if (rst)
            arm_q <= 1'b0;
        else if (ovf_evt || ctrl_wr)
            arm_q <= 1'b0;
        else if (ctrl_rd && ctrl_q.flag)
            arm_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q          <= '1;
            mod_hi_stage_q <= '1;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(RA_MOD_HI))
                mod_hi_stage_q <= bus_wdata;
            else if (bus_addr == ADDR_W'(RA_MOD_LO))
                mod_q <= {mod_hi_stage_q, bus_wdata};
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(RA_CTRL): begin
                bus_rdata[B_FLAG]           = ctrl_q.flag;
                bus_rdata[B_IEN]            = ctrl_q.ien;
                bus_rdata[B_HALT]           = ctrl_q.halt;
                bus_rdata[B_SEL +: SEL_W]   = ctrl_q.sel;
            end
            ADDR_W'(RA_CNT_HI): bus_rdata = count[CNT_W-1 -: DATA_W];
            ADDR_W'(RA_CNT_LO): bus_rdata = count[DATA_W-1:0];
            ADDR_W'(RA_MOD_HI): bus_rdata = mod_q[CNT_W-1 -: DATA_W];
            ADDR_W'(RA_MOD_LO): bus_rdata = mod_q[DATA_W-1:0];
            default:            bus_rdata = '0;
        endcase
    end

    assign halt   = ctrl_q.halt;
    assign sel    = ctrl_q.sel;
    assign modulo = mod_q;
    assign flag   = ctrl_q.flag;
    assign ien    = ctrl_q.ien;
    assign irq    = ctrl_q.flag & ctrl_q.ien;

endmodule

// File: rtl/presc_mod_timer.sv
module presc_mod_timer #(
    parameter int DATA_W = presc_mod_timer_pkg::DATA_W,
    parameter int ADDR_W = presc_mod_timer_pkg::ADDR_W,
    parameter int SEL_W  = presc_mod_timer_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic             restart_w, halt_w, tick_w, ovf_w, flag_w, ien_w;
    logic [SEL_W-1:0] sel_w;
    logic [CNT_W-1:0] count_w, modulo_w;

    presc_mod_timer_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count_w), .ovf_evt(ovf_w),
        .halt(halt_w), .sel(sel_w), .restart(restart_w),
        .modulo(modulo_w), .flag(flag_w), .ien(ien_w), .irq(irq)
    );

    presc_mod_timer_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst(rst), .restart(restart_w), .halt(halt_w),
        .sel(sel_w), .ext_in(ext_clk), .tick(tick_w)
    );

    presc_mod_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .restart(restart_w), .tick(tick_w),
        .modulo(modulo_w), .count(count_w), .ovf_evt(ovf_w)
    );

endmodule

// File: rtl/presc_mod_timer_chk.sv
module presc_mod_timer_chk #(
    parameter int DATA_W = presc_mod_timer_pkg::DATA_W,
    parameter int ADDR_W = presc_mod_timer_pkg::ADDR_W,
    parameter int CNT_W  = presc_mod_timer_pkg::CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  modulo,
    input logic              halt,
    input logic              flag
);
    import presc_mod_timer_pkg::*;

    logic ctl_wr, rs_wr, unused_chk;
    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
    assign rs_wr  = ctl_wr && bus_wdata[B_RSTRT];
    assign unused_chk = ^bus_wdata;

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (halt && !rs_wr) |=> (count == $past(count)));

    a_r11_restart_zero: assert property (@(posedge clk) disable iff (rst)
        rs_wr |=> (count == '0));

    a_r12_halt_restart: assert property (@(posedge clk) disable iff (rst)
        (rs_wr && bus_wdata[B_HALT]) |=> (count == '0 && halt));

    a_r5_flag_at_modulo: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (count == $past(modulo)));

    a_r6_clear_by_write0: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(ctl_wr && !bus_wdata[B_FLAG]));

    a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |->
            (count == CNT_W'($past(count) + CNT_W'(1)) || count == '0));

endmodule

bind presc_mod_timer presc_mod_timer_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .count(count_w), .modulo(modulo_w),
    .halt(halt_w), .flag(flag_w)
);

// File: tb/sim_presc_mod_timer.sv
`timescale 1ns/1ps
module sim_presc_mod_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [2:0] A_CTL = 3'd0, A_CH = 3'd1, A_CL = 3'd2,
                           A_MH = 3'd3, A_ML = 3'd4;

    always #10 clk = ~clk;

    presc_mod_timer u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .irq(irq)
    );

    function automatic logic [7:0] ctl(input bit f, input bit en,
                                       input bit h, input bit rs,
                                       input int s);
        return {1'b0, 3'(s), rs, h, en, f};
    endfunction

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTL, v); check("R1 ctrl", v, 8'h04);
        rd(A_CH, v);  check("R1 cnt hi", v, 8'h00);
        rd(A_CL, v);  check("R1 cnt lo", v, 8'h00);
        rd(A_MH, v);  check("R1 mod hi", v, 8'hFF);
        rd(A_ML, v);  check("R1 mod lo", v, 8'hFF);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        for (int k = 0; k < 7; k++) begin
            wr(A_CTL, ctl(0, 0, 0, 1, k));
            repeat (200) @(negedge clk);
            rd(A_CL, v);
            check($sformatf("R2 code %0d", k), v, (200 >> k) & 8'hFF);
        end
    endtask

    task automatic t_extclk();
        logic [7:0] v;
        wr(A_CTL, ctl(0, 0, 0, 1, 7));
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1; repeat (3) @(negedge clk);
            ext_clk = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(A_CL, v); check("R3 ext edges", v, 5);
        repeat (40) @(negedge clk);
        rd(A_CL, v); check("R3 steady ext", v, 5);
    endtask

    task automatic t_modulo();
        logic [7:0] v;
        wr(A_CTL, ctl(0, 0, 1, 0, 0));
        wr(A_MH, 8'h00);
        rd(A_MH, v); check("R4 staged hi", v, 8'hFF);
        wr(A_ML, 8'h05);
        rd(A_MH, v); check("R4 mod hi", v, 8'h00);
        rd(A_ML, v); check("R4 mod lo", v, 8'h05);
        wr(A_CTL, ctl(0, 0, 1, 1, 0));
        wr(A_CTL, ctl(0, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        rd(A_CTL, v); check("R5 flag before", v[0], 0);
        rd(A_CL, v);  check("R5 count at mod", v, 5);
        rd(A_CL, v);  check("R4 wrap", v, 0);
        rd(A_CTL, v); check("R5 flag set", v[0], 1);
    endtask

    task automatic t_flag_clear();
        logic [7:0] v;
        rd(A_CTL, v);
        wr(A_CTL, ctl(1, 0, 1, 0, 0));
        wr(A_CTL, ctl(0, 0, 1, 0, 0));
        rd(A_CTL, v); check("R6 R8 no clear unarmed", v[0], 1);
        wr(A_CTL, ctl(0, 0, 1, 0, 0));
        rd(A_CTL, v); check("R6 armed clear", v[0], 0);
        wr(A_CTL, ctl(1, 0, 1, 0, 0));
        rd(A_CTL, v); check("R8 write1 no set", v[0], 0);
    endtask

    task automatic t_flag_race();
        logic [7:0] v;
        wr(A_CTL, ctl(1, 0, 1, 1, 0));
        wr(A_CTL, ctl(1, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        rd(A_CTL, v); check("R7 flag up", v[0], 1);
        repeat (5) @(negedge clk);
        wr(A_CTL, ctl(0, 0, 1, 0, 0));
        rd(A_CTL, v); check("R7 clear cancelled", v[0], 1);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        check("R9 irq en off", irq, 0);
        wr(A_CTL, ctl(1, 1, 1, 0, 0));
        check("R9 irq on", irq, 1);
        rd(A_CTL, v);
        wr(A_CTL, ctl(0, 1, 1, 0, 0));
        check("R9 irq after clear", irq, 0);
    endtask

    task automatic t_halt();
        logic [7:0] v, a;
        wr(A_CTL, ctl(1, 1, 1, 1, 0));
        repeat (20) @(negedge clk);
        rd(A_CL, v);  check("R12 lo zero", v, 0);
        rd(A_CH, v);  check("R12 hi zero", v, 0);
        rd(A_CTL, v); check("R11 restart reads 0", v, 8'h06);
        wr(A_CTL, ctl(1, 1, 0, 0, 0));
        repeat (3) @(negedge clk);
        rd(A_CL, v);  check("R10 resume", v, 3);
        wr(A_CTL, ctl(1, 1, 1, 0, 0));
        rd(A_CL, a);
        repeat (10) @(negedge clk);
        rd(A_CL, v);  check("R10 hold", v, a);
    endtask

    task automatic t_restart_keeps();
        logic [7:0] v;
        wr(A_CTL, ctl(1, 1, 0, 1, 2));
        repeat (3) @(negedge clk);
        rd(A_CL, v);  check("R11 divider cleared", v, 0);
        rd(A_CL, v);  check("R11 first tick", v, 1);
        rd(A_CTL, v); check("R11 fields kept", v & 8'hFE, 8'h22);
        rd(A_ML, v);  check("R11 modulo kept", v, 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_extclk();
        t_modulo();
        t_flag_clear();
        t_flag_race();
        t_irq();
        t_halt();
        t_restart_keeps();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule